// File: doc/BRIEF.md
# ULPI Link-Side PHY Register Access Controller

This block lives on the controller side of a ULPI bus and turns simple local requests into PHY register reads and writes. A request is a one-cycle strobe with a read/write flag, an 8-bit register address, write data and a flag that forces the long address form. When the operation finishes the block pulses a completion flag, with an error flag beside it when the address cannot be reached, and for reads it presents the byte it fetched.

On the ULPI side the block drives the 8-bit data bus, its output enable and STP, and it samples DIR and NXT. All of this runs in the ULPI clock domain. While nothing is pending it holds the no-operation byte on the bus. It hands the bus to the PHY whenever DIR rises and waits out the turnaround cycles. If the PHY takes the bus before a byte has been acknowledged, the block abandons the access and starts it again from the command byte. After reset it sends no command until it has seen DIR low for three consecutive clocks.

Top module: `ulpi_regacc_ctrl`

## Requirements
- R1: While no operation is in progress and DIR is low, the block drives 00h on the data bus with the output enable high and STP low.
- R2: After reset, no command byte is driven until DIR has been sampled low on 3 consecutive clocks. A DIR high sample before that point restarts the count. A request accepted during this wait is held and then sent.
- R3: The output enable is low whenever DIR is high. It is also low in the first clock after DIR was sampled high, so the block drives again only from the second clock after DIR falls.
- R4: A write sends the command byte {2'b10, addr[5:0]} and holds it until NXT is sampled high. It then holds the write data until NXT is sampled high. In the next clock it drives STP high with 00h on the bus, and in the clock after that it pulses done.
- R5: A read sends {2'b11, addr[5:0]} and holds it until NXT is sampled high, then releases the bus. It captures data_i in the first clock where DIR is high after the turnaround clock. It pulses done, with rd_data holding the captured byte, in the clock after DIR is sampled low again.
- R6: When req_ext is set, or addr[5:0] equals 2Fh, the 6-bit field of the command carries 2Fh. The full 8-bit address follows as a separate byte, held until NXT is sampled high, before the write data or the read turnaround.
- R7: A request with an address above MAX_ADDR (3Fh by default) puts nothing on the bus. The bus stays at 00h, and the block pulses done and error together in the next clock.
- R8: If DIR is sampled high while a command, address or write-data byte is waiting for NXT, the block stops driving. Once DIR is low again it repeats the whole access from the command byte, and it pulses done only once.
- R9: A request strobe that arrives while an operation is in progress is ignored, and no second access follows.
- R10: done and error are single-clock pulses for a single request, and error is never high without done.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | ULPI clock |
| rst | input | 1 | Synchronous active-high reset |
| req_valid | input | 1 | Request strobe, one clock |
| req_write | input | 1 | 1 = register write, 0 = register read |
| req_ext | input | 1 | Force the long (escaped) address form |
| req_addr | input | 8 | Register address |
| req_wdata | input | 8 | Write data |
| rd_data | output | 8 | Last byte fetched by a read |
| op_done | output | 1 | Completion pulse |
| op_error | output | 1 | Unreachable address, pulsed with op_done |
| ulpi_dir | input | 1 | Bus direction from the PHY |
| ulpi_nxt | input | 1 | Byte acknowledge from the PHY |
| ulpi_data_i | input | 8 | Data bus as seen from the PHY side |
| ulpi_data_o | output | 8 | Data bus value driven by the link |
| ulpi_data_oe | output | 1 | Link output enable for the data bus |
| ulpi_stp | output | 1 | STP line |

## Verification
The hardest situation to reach is the abandoned access. The PHY has to seize the bus at exactly the clock when a command byte sits unacknowledged, and then release it so that the retry can be observed. The bench PHY model watches the bus for the expected command byte. In that clock it raises DIR instead of NXT, holds DIR for a few clocks, and checks that the enable stays low through the falling-edge turnaround. It then acknowledges the repeated command and expects exactly one completion. The power-up wait is approached in a similar way: a short run of low DIR clocks is broken by a high clock before the steady low run.

// File: rtl/ulpi_regacc_pkg.sv
package ulpi_regacc_pkg;
  localparam int          IMM_W     = 6;
  localparam logic [1:0]  OP_WR     = 2'b10;
  localparam logic [1:0]  OP_RD     = 2'b11;
  localparam logic [5:0]  ESC_FIELD = 6'h2F;

  typedef enum logic [3:0] {
    ST_IDLE, ST_WAIT, ST_CMD, ST_EXT, ST_WDAT, ST_STP, ST_RTA, ST_RCAP, ST_REND
  } xfer_st_t;
endpackage

// File: rtl/ulpi_pwrup_gate.sv
module ulpi_pwrup_gate #(
  parameter int LOW_CYCLES = 3
) (
  input  logic clk,
  input  logic rst,
  input  logic ulpi_dir,
  output logic ready
);
  localparam int CNT_W = $clog2(LOW_CYCLES + 1);
  localparam logic [CNT_W-1:0] LAST = CNT_W'(LOW_CYCLES - 1);

  logic [CNT_W-1:0] low_cnt;
  logic             ready_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      low_cnt <= '0;
      ready_q <= 1'b0;
    end else if (!ready_q) begin
      if (ulpi_dir)             low_cnt <= '0;
      else if (low_cnt == LAST) ready_q <= 1'b1;
      else                      low_cnt <= low_cnt + 1'b1;
    end
  end

  assign ready = ready_q;

  // R2: once granted, the permission to send commands stays until reset
  assert_ready_sticky_R2: assert property (@(posedge clk) disable iff (rst)
    ready_q |=> ready_q);
endmodule

// File: rtl/ulpi_req_decode.sv
module ulpi_req_decode
  import ulpi_regacc_pkg::*;
#(
  parameter int ADDR_W = 8,
  parameter logic [ADDR_W-1:0] MAX_ADDR = 8'h3F
) (
  input  logic [ADDR_W-1:0] addr,
  input  logic              ext_req,
  output logic              bad_addr,
  output logic              use_ext
);
  always_comb begin
    bad_addr = (addr > MAX_ADDR);
    use_ext  = ext_req || (addr[IMM_W-1:0] == ESC_FIELD);
  end
endmodule

// File: rtl/ulpi_xfer_fsm.sv
module ulpi_xfer_fsm
  import ulpi_regacc_pkg::*;
#(
  parameter int ADDR_W = 8,
  parameter int BUS_W  = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              req_valid,
  input  logic              req_write,
  input  logic [ADDR_W-1:0] req_addr,
  input  logic [BUS_W-1:0]  req_wdata,
  input  logic              dec_bad,
  input  logic              dec_ext,
  input  logic              pw_ready,
  input  logic              ulpi_dir,
  input  logic              ulpi_nxt,
  input  logic [BUS_W-1:0]  ulpi_data_i,
  output logic [BUS_W-1:0]  rd_data,
  output logic              op_done,
  output logic              op_error,
  output logic [BUS_W-1:0]  bus_data,
  output logic              bus_oe_q,
  output logic              bus_stp
);
  xfer_st_t          st_q, st_n;
  logic              op_wr_q, op_ext_q;
  logic [ADDR_W-1:0] op_addr_q;
  logic [BUS_W-1:0]  op_wdata_q, rdata_q, data_q, data_n;
  logic              done_q, err_q, oe_q, stp_q;
  logic              take, done_n, err_n, cap;
  logic              oe_n;
  logic              awaiting_ack;

  always_comb begin
    st_n   = st_q;
    take   = 1'b0;
    done_n = 1'b0;
    err_n  = 1'b0;
    cap    = 1'b0;
    unique case (st_q)
      ST_IDLE: if (req_valid) begin
        if (dec_bad) begin
          done_n = 1'b1;
          err_n  = 1'b1;
        end else begin
          take = 1'b1;
          st_n = ST_WAIT;
        end
      end
      ST_WAIT: if (pw_ready && !ulpi_dir) st_n = ST_CMD;
      ST_CMD: begin
        if (ulpi_dir)      st_n = ST_WAIT;
        else if (ulpi_nxt) st_n = op_ext_q ? ST_EXT : (op_wr_q ? ST_WDAT : ST_RTA);
      end
      ST_EXT: begin
        if (ulpi_dir)      st_n = ST_WAIT;
        else if (ulpi_nxt) st_n = op_wr_q ? ST_WDAT : ST_RTA;
      end
      ST_WDAT: begin
        if (ulpi_dir)      st_n = ST_WAIT;
        else if (ulpi_nxt) st_n = ST_STP;
      end
      ST_STP: begin
        st_n   = ST_IDLE;
        done_n = 1'b1;
      end
      ST_RTA:  if (ulpi_dir) st_n = ST_RCAP;
      ST_RCAP: begin
        cap  = ulpi_dir;
        st_n = ST_REND;
      end
      ST_REND: if (!ulpi_dir) begin
        st_n   = ST_IDLE;
        done_n = 1'b1;
      end
      default: st_n = ST_IDLE;
    endcase
  end

  // byte and enable for the next clock, taken from the next state
  always_comb begin
    unique case (st_n)
      ST_CMD:  data_n = {(op_wr_q ? OP_WR : OP_RD),
                         (op_ext_q ? ESC_FIELD : op_addr_q[IMM_W-1:0])};
      ST_EXT:  data_n = BUS_W'(op_addr_q);
      ST_WDAT: data_n = op_wdata_q;
      default: data_n = '0;
    endcase
    oe_n = !ulpi_dir && !(st_n inside {ST_RTA, ST_RCAP, ST_REND});
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      st_q       <= ST_IDLE;
      op_wr_q    <= 1'b0;
      op_ext_q   <= 1'b0;
      op_addr_q  <= '0;
      op_wdata_q <= '0;
      rdata_q    <= '0;
      done_q     <= 1'b0;
      err_q      <= 1'b0;
      data_q     <= '0;
      oe_q       <= 1'b0;
      stp_q      <= 1'b0;
    end else begin
      st_q   <= st_n;
      done_q <= done_n;
      err_q  <= err_n;
      data_q <= data_n;
      oe_q   <= oe_n;
      stp_q  <= (st_n == ST_STP);
      if (take) begin
        op_wr_q    <= req_write;
        op_ext_q   <= dec_ext;
        op_addr_q  <= req_addr;
        op_wdata_q <= req_wdata;
      end
      if (cap) rdata_q <= ulpi_data_i;
    end
  end

  assign rd_data  = rdata_q;
  assign op_done  = done_q;
  assign op_error = err_q;
  assign bus_data = data_q;
  assign bus_oe_q = oe_q;
  assign bus_stp  = stp_q;

  assign awaiting_ack = st_q inside {ST_CMD, ST_EXT, ST_WDAT};

  // R2: a command goes out only after the power-up permission
  assert_cmd_after_pwrup_R2: assert property (@(posedge clk) disable iff (rst)
    (st_q == ST_CMD) |-> pw_ready);
  // R4: STP follows an acknowledged byte
  assert_stp_after_ack_R4: assert property (@(posedge clk) disable iff (rst)
    stp_q |-> $past(ulpi_nxt));
  // R4: STP lasts one clock
  assert_stp_single_R4: assert property (@(posedge clk) disable iff (rst)
    stp_q |=> !stp_q);
  // R4, R6: an unacknowledged byte is held
  assert_byte_held_R6: assert property (@(posedge clk) disable iff (rst)
    (awaiting_ack && !ulpi_nxt && !ulpi_dir) |=> $stable(data_q));
  // R10: error only with done
  assert_err_with_done_R10: assert property (@(posedge clk) disable iff (rst)
    err_q |-> done_q);
  // R1: idle bus carries the no-operation byte
  assert_idle_noop_R1: assert property (@(posedge clk) disable iff (rst)
    (st_q == ST_IDLE) |-> (data_q == '0) && !stp_q);
endmodule

// File: rtl/ulpi_regacc_ctrl.sv
module ulpi_regacc_ctrl
  import ulpi_regacc_pkg::*;
#(
  parameter int ADDR_W = 8,
  parameter int BUS_W  = 8,
  parameter int PWRUP_LOW_CYCLES = 3,
  parameter logic [ADDR_W-1:0] MAX_ADDR = 8'h3F
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              req_valid,
  input  logic              req_write,
  input  logic              req_ext,
  input  logic [ADDR_W-1:0] req_addr,
  input  logic [BUS_W-1:0]  req_wdata,
  output logic [BUS_W-1:0]  rd_data,
  output logic              op_done,
  output logic              op_error,
  input  logic              ulpi_dir,
  input  logic              ulpi_nxt,
  input  logic [BUS_W-1:0]  ulpi_data_i,
  output logic [BUS_W-1:0]  ulpi_data_o,
  output logic              ulpi_data_oe,
  output logic              ulpi_stp
);
  logic pw_ready, dec_bad, dec_ext, oe_q;

  ulpi_pwrup_gate #(.LOW_CYCLES(PWRUP_LOW_CYCLES)) pwrup_i (
    .clk(clk), .rst(rst), .ulpi_dir(ulpi_dir), .ready(pw_ready));

  ulpi_req_decode #(.ADDR_W(ADDR_W), .MAX_ADDR(MAX_ADDR)) dec_i (
    .addr(req_addr), .ext_req(req_ext), .bad_addr(dec_bad), .use_ext(dec_ext));

  ulpi_xfer_fsm #(.ADDR_W(ADDR_W), .BUS_W(BUS_W)) fsm_i (
    .clk(clk), .rst(rst), .req_valid(req_valid), .req_write(req_write),
    .req_addr(req_addr), .req_wdata(req_wdata), .dec_bad(dec_bad),
    .dec_ext(dec_ext), .pw_ready(pw_ready), .ulpi_dir(ulpi_dir),
    .ulpi_nxt(ulpi_nxt), .ulpi_data_i(ulpi_data_i), .rd_data(rd_data),
    .op_done(op_done), .op_error(op_error), .bus_data(ulpi_data_o),
    .bus_oe_q(oe_q), .bus_stp(ulpi_stp));

  // release the bus in the same clock DIR rises
  assign ulpi_data_oe = oe_q && !ulpi_dir;

  // R3: never drive while DIR is high or in the clock after it was high
  assert_no_contention_R3: assert property (@(posedge clk) disable iff (rst)
    ulpi_data_oe |-> !ulpi_dir && !$past(ulpi_dir));
endmodule

// File: tb/ulpi_regacc_ctrl_tb_top.sv
`timescale 1ns/1ps
module ulpi_regacc_ctrl_tb_top;
  logic clk = 1'b0;
  logic rst;
  logic req_valid, req_write, req_ext;
  logic [7:0] req_addr, req_wdata, rd_data;
  logic op_done, op_error;
  logic ulpi_dir, ulpi_nxt;
  logic [7:0] ulpi_data_i, ulpi_data_o;
  logic ulpi_data_oe, ulpi_stp;
  int checks = 0;
  int errors = 0;
  bit finished = 0;

  always #2.5 clk = ~clk;

  ulpi_regacc_ctrl dut_i (
    .clk(clk), .rst(rst), .req_valid(req_valid), .req_write(req_write),
    .req_ext(req_ext), .req_addr(req_addr), .req_wdata(req_wdata),
    .rd_data(rd_data), .op_done(op_done), .op_error(op_error),
    .ulpi_dir(ulpi_dir), .ulpi_nxt(ulpi_nxt), .ulpi_data_i(ulpi_data_i),
    .ulpi_data_o(ulpi_data_o), .ulpi_data_oe(ulpi_data_oe), .ulpi_stp(ulpi_stp));

  task automatic tick();
    @(negedge clk);
  endtask

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic do_reset(input logic dir_val);
    rst = 1; req_valid = 0; req_write = 0; req_ext = 0; req_addr = 0;
    req_wdata = 0; ulpi_dir = dir_val; ulpi_nxt = 0; ulpi_data_i = 0;
    repeat (4) tick();
    rst = 0;
  endtask

  task automatic issue(input logic w, input logic ext, input [7:0] a, input [7:0] d);
    req_valid = 1; req_write = w; req_ext = ext; req_addr = a; req_wdata = d;
    tick();
    req_valid = 0;
  endtask

  // watch for a byte; answer it with NXT, or seize the bus with DIR
  task automatic wait_byte(input [7:0] exp, input string req, input bit seize);
    bit found = 0;
    for (int i = 0; i < 20 && !found; i++) begin
      tick();
      if (ulpi_data_oe && ulpi_data_o == exp) found = 1;
    end
    chk(found, req, ulpi_data_o, exp);
    if (seize) ulpi_dir = 1; else ulpi_nxt = 1;
  endtask

  task automatic finish_write(input string req);
    tick(); ulpi_nxt = 0;
    chk(ulpi_stp && ulpi_data_oe && ulpi_data_o == 8'h00, req, {ulpi_stp, ulpi_data_o}, 9'h100);
    tick();
    chk(op_done && !op_error && !ulpi_stp, req, {op_done, op_error}, 2'b10);
    tick();
    chk(!op_done, "R10 done single pulse", op_done, 0);
  endtask

  task automatic finish_read(input [7:0] val, input string req);
    tick(); ulpi_nxt = 0; ulpi_dir = 1; #1;
    chk(!ulpi_data_oe, "R3 released on DIR rise", ulpi_data_oe, 0);
    tick(); ulpi_data_i = val;
    tick(); ulpi_dir = 0; ulpi_data_i = 8'h33; #1;
    chk(!ulpi_data_oe, "R3 turnaround after DIR fall", ulpi_data_oe, 0);
    tick();
    chk(op_done && rd_data == val, req, rd_data, val);
    chk(ulpi_data_oe && ulpi_data_o == 8'h00, "R3 drives again after turnaround", ulpi_data_oe, 1);
  endtask

  task automatic t_reset();
    do_reset(1'b0);
    rst = 1; tick();
    chk(!op_done && !op_error && !ulpi_stp && !ulpi_data_oe, "R1 reset state",
        {op_done, op_error, ulpi_stp, ulpi_data_oe}, 0);
    rst = 0;
    repeat (5) tick();
    chk(ulpi_data_oe && ulpi_data_o == 8'h00 && !ulpi_stp, "R1 idle NOOP",
        ulpi_data_o, 0);
  endtask

  task automatic t_write_imm();
    issue(1, 0, 8'h0A, 8'h5C);
    wait_byte(8'h8A, "R4 write command", 0);
    tick(); ulpi_nxt = 0;
    chk(ulpi_data_o == 8'h5C, "R4 data after ack", ulpi_data_o, 8'h5C);
    wait_byte(8'h5C, "R4 write data", 0);
    finish_write("R4 write completion");
  endtask

  task automatic t_read_imm();
    issue(0, 0, 8'h15, 8'h00);
    wait_byte(8'hD5, "R5 read command", 0);
    finish_read(8'hA7, "R5 read data");
  endtask

  task automatic t_ext_read();
    issue(0, 1, 8'h07, 8'h00);
    wait_byte(8'hEF, "R6 extended read command", 0);
    tick(); ulpi_nxt = 0;
    wait_byte(8'h07, "R6 extended address byte", 0);
    finish_read(8'h5A, "R6 extended read data");
  endtask

  task automatic t_esc_write();
    issue(1, 0, 8'h2F, 8'hC3);
    wait_byte(8'hAF, "R6 escaped write command", 0);
    tick(); ulpi_nxt = 0;
    wait_byte(8'h2F, "R6 escaped address byte", 0);
    tick(); ulpi_nxt = 0;
    wait_byte(8'hC3, "R6 escaped write data", 0);
    finish_write("R6 escaped write completion");
  endtask

  task automatic t_bad_addr();
    issue(1, 0, 8'h80, 8'h12);
    chk(op_done && op_error, "R7 error pulse", {op_done, op_error}, 2'b11);
    for (int i = 0; i < 5; i++) begin
      tick();
      chk(ulpi_data_oe && ulpi_data_o == 8'h00 && !op_done && !op_error,
          "R7 R10 no bus activity", ulpi_data_o, 0);
    end
  endtask

  task automatic t_abort();
    issue(1, 0, 8'h04, 8'h99);
    wait_byte(8'h84, "R8 command before abort", 1);
    for (int i = 0; i < 3; i++) begin
      tick();
      chk(!ulpi_data_oe && !op_done, "R8 bus released during abort", ulpi_data_oe, 0);
    end
    ulpi_dir = 0; #1;
    chk(!ulpi_data_oe, "R3 no drive in turnaround", ulpi_data_oe, 0);
    wait_byte(8'h84, "R8 command retried", 0);
    tick(); ulpi_nxt = 0;
    wait_byte(8'h99, "R8 data after retry", 0);
    finish_write("R8 retried write completion");
    repeat (3) begin
      tick();
      chk(!op_done, "R8 single completion", op_done, 0);
    end
  endtask

  task automatic t_busy();
    issue(1, 0, 8'h03, 8'h44);
    wait_byte(8'h83, "R9 first command", 0);
    tick(); ulpi_nxt = 0;
    req_valid = 1; req_write = 1; req_addr = 8'h05; req_wdata = 8'h66;
    tick(); req_valid = 0;
    wait_byte(8'h44, "R9 first data", 0);
    finish_write("R9 first completion");
    for (int i = 0; i < 6; i++) begin
      tick();
      chk(ulpi_data_o == 8'h00 && !op_done, "R9 busy request ignored", ulpi_data_o, 0);
    end
  endtask

  task automatic t_powerup();
    do_reset(1'b1);
    issue(1, 0, 8'h01, 8'h11);
    repeat (3) tick();
    ulpi_dir = 0;
    for (int i = 0; i < 2; i++) begin
      tick();
      chk(ulpi_data_o == 8'h00, "R2 no command before 3 lows", ulpi_data_o, 0);
    end
    ulpi_dir = 1; tick();
    ulpi_dir = 0;
    for (int i = 0; i < 3; i++) begin
      tick();
      chk(ulpi_data_o == 8'h00, "R2 count restarted by DIR high", ulpi_data_o, 0);
    end
    wait_byte(8'h81, "R2 held request sent", 0);
    tick(); ulpi_nxt = 0;
    wait_byte(8'h11, "R2 data", 0);
    finish_write("R2 completion");
  endtask

  initial begin
    t_reset();
    t_write_imm();
    t_read_imm();
    t_ext_read();
    t_esc_write();
    t_bad_addr();
    t_abort();
    t_busy();
    t_powerup();
    finished = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      checks++; errors++;
      $display("FAIL watchdog: actual=%0h expected=%0h", 0, 1);
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end
endmodule